// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Exception Entry

This block is the control sequencer of a small multicycle processor. Every instruction takes several clock cycles. The sequencer walks through one state per cycle and drives the datapath's control lines from its current state. Every instruction starts with a fetch step and a decode step. In the decode cycle the sequencer reads the opcode field of the instruction register and picks one of these paths:

- a register-to-register arithmetic path;
- a load path;
- a store path;
- a conditional branch path;
- an unconditional jump path.

Two abnormal events leave the normal paths:

- **Unsupported opcode.** An opcode that is not supported enters an illegal-instruction state.
- **ALU overflow.** An overflow reported by the ALU during register-to-register execution enters an overflow state. The result is not written back.

Each of these states records its cause code for one cycle. Both then pass through one shared handler-entry state. That state saves the program counter minus four into the exception PC register and loads the handler address into the program counter. Control then returns to fetch.

The outputs are a pure function of the state register, so every control line is glitch-free with respect to the inputs. The opcode is sampled only in the decode cycle. The overflow flag is sampled only in the register-to-register execute cycle.

Top module: `seqctl_top`

## Requirements

Field encodings used below:

| Field | Code | Meaning |
|---|---|---|
| `alu_a_sel` | 0 | PC |
| `alu_a_sel` | 1 | register A |
| `alu_b_sel` | 0 | register B |
| `alu_b_sel` | 1 | constant 4 |
| `alu_b_sel` | 2 | sign-extended immediate |
| `alu_b_sel` | 3 | immediate shifted left by two |
| `alu_op` | 0 | add |
| `alu_op` | 1 | subtract |
| `alu_op` | 2 | use the function field |
| `pc_src` | 0 | ALU result |
| `pc_src` | 1 | ALU output register |
| `pc_src` | 2 | jump target |
| `pc_src` | 3 | handler address |

Any control line not listed for a state is 0.

- R1: A synchronous active-high `rst` places the sequencer in the fetch state on the next rising clock edge, from any state. While `rst` is held, the fetch control vector is driven.
- R2: In fetch, the sequencer asserts `mem_rd`, `ir_load` and `pc_load`, with `addr_sel_data`=0, `alu_a_sel`=0, `alu_b_sel`=1, `alu_op`=0 and `pc_src`=0. The next state is always decode.
- R3: In decode, the sequencer drives `alu_a_sel`=0, `alu_b_sel`=3 and `alu_op`=0, with nothing written. The next state is chosen by opcode:
  - 0x00 goes to register execute;
  - 0x23 goes to the load address step;
  - 0x2B goes to the store address step;
  - 0x04 goes to branch;
  - 0x02 goes to jump.
- R4: Register execute drives `alu_a_sel`=1, `alu_b_sel`=0 and `alu_op`=2. With `alu_ovf` low it is followed by writeback (`rf_we`=1, `wr_dst_rd`=1, `wb_from_mem`=0) and then fetch. The whole instruction takes four cycles.
- R5: A load takes five cycles:
  - fetch;
  - decode;
  - address (`alu_a_sel`=1, `alu_b_sel`=2, `alu_op`=0);
  - memory read (`mem_rd`=1, `addr_sel_data`=1);
  - register write (`rf_we`=1, `wr_dst_rd`=0, `wb_from_mem`=1).
- R6: A store takes four cycles: fetch, decode, the same address step as a load, and a memory write (`mem_wr`=1, `addr_sel_data`=1).
- R7: A branch takes three cycles. Its last cycle drives `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=1, `pc_load_cond`=1 and `pc_src`=1.
- R8: A jump takes three cycles. Its last cycle drives `pc_load`=1 with `pc_src`=2.
- R9: An opcode outside the five supported values leads from decode to a cycle with `cause_load`=1 and `cause_code`=0. The handler-entry state follows.
- R10: When `alu_ovf` is high in the register execute cycle, the next cycle drives `cause_load`=1 with `cause_code`=1 instead of writeback. `rf_we` is not asserted for that instruction, and the handler-entry state follows.
- R11: The handler-entry state drives:
  - `epc_load`=1;
  - `alu_a_sel`=0, `alu_b_sel`=1 and `alu_op`=1, so the ALU computes PC minus four;
  - `pc_load`=1 with `pc_src`=3.

  The next state is fetch.
- R12: `opcode` has no effect outside the decode cycle, and `alu_ovf` has no effect outside the register execute cycle. The control vector in each cycle depends only on the state.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset/start |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_ovf | input | 1 | ALU signed-overflow flag |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| addr_sel_data | output | 1 | Memory address from ALU output register (1) or PC (0) |
| ir_load | output | 1 | Instruction register load |
| alu_a_sel | output | 1 | ALU operand A select |
| alu_b_sel | output | 2 | ALU operand B select |
| alu_op | output | 2 | ALU operation select |
| pc_load | output | 1 | Unconditional PC load |
| pc_load_cond | output | 1 | PC load qualified by the ALU zero result |
| pc_src | output | 2 | Next-PC source select |
| wr_dst_rd | output | 1 | Register destination from the rd field (1) or rt field (0) |
| rf_we | output | 1 | Register file write enable |
| wb_from_mem | output | 1 | Writeback data from memory data register (1) or ALU (0) |
| epc_load | output | 1 | Exception PC register load |
| cause_load | output | 1 | Cause register load |
| cause_code | output | 1 | Cause value: 0 illegal opcode, 1 overflow |

## Verification

Every state except the two address steps has its own control vector. A wrong state is therefore visible at the ports in the same cycle it is entered.

A mix-up between the load and store address steps stays hidden for exactly one cycle. It then shows up as a read where a write was expected, or the reverse.

The bench drives random junk on `opcode` and `alu_ovf` in every cycle where they must be ignored. A sequencer that samples them at the wrong time therefore leaves its path within one cycle. The bench also compares the full vector against a per-class step list in every cycle, so a missing or extra cycle shows up immediately as a misaligned vector.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

    localparam int OPC_W   = 6;
    localparam int ST_W    = 4;
    localparam int BSEL_W  = 2;
    localparam int AOP_W   = 2;
    localparam int PCS_W   = 2;

    // Supported opcode values
    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;

    // Cause codes
    localparam logic CAUSE_ILLEGAL = 1'b0;
    localparam logic CAUSE_OVF     = 1'b1;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_LADDR   = 4'd2,
        ST_MREAD   = 4'd3,
        ST_LDWB    = 4'd4,
        ST_SADDR   = 4'd5,
        ST_MWRITE  = 4'd6,
        ST_REXEC   = 4'd7,
        ST_RWB     = 4'd8,
        ST_BRANCH  = 4'd9,
        ST_JUMP    = 4'd10,
        ST_ILLEGAL = 4'd11,
        ST_OVFL    = 4'd12,
        ST_TRAP    = 4'd13
    } state_e;

    typedef enum logic [BSEL_W-1:0] {
        BSEL_REG   = 2'd0,
        BSEL_FOUR  = 2'd1,
        BSEL_IMM   = 2'd2,
        BSEL_IMMSH = 2'd3
    } bsel_e;

    typedef enum logic [AOP_W-1:0] {
        AOP_ADD  = 2'd0,
        AOP_SUB  = 2'd1,
        AOP_FUNC = 2'd2,
        AOP_RSVD = 2'd3
    } aop_e;

    typedef enum logic [PCS_W-1:0] {
        PCS_ALU     = 2'd0,
        PCS_ALUREG  = 2'd1,
        PCS_JTGT    = 2'd2,
        PCS_HANDLER = 2'd3
    } pcsrc_e;

    typedef struct packed {
        logic   mem_rd;
        logic   mem_wr;
        logic   addr_data;
        logic   ir_ld;
        logic   a_reg;
        bsel_e  b_sel;
        aop_e   alu_op;
        logic   pc_ld;
        logic   pc_ld_cond;
        pcsrc_e pc_src;
        logic   dst_rd;
        logic   rf_we;
        logic   wb_mem;
        logic   epc_ld;
        logic   cause_ld;
        logic   cause_code;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        mem_rd: 1'b0, mem_wr: 1'b0, addr_data: 1'b0, ir_ld: 1'b0,
        a_reg: 1'b0, b_sel: BSEL_REG, alu_op: AOP_ADD, pc_ld: 1'b0,
        pc_ld_cond: 1'b0, pc_src: PCS_ALU, dst_rd: 1'b0, rf_we: 1'b0,
        wb_mem: 1'b0, epc_ld: 1'b0, cause_ld: 1'b0, cause_code: 1'b0
    };

    // Opcode dispatch out of the decode state
    function automatic state_e dispatch(input logic [OPC_W-1:0] op);
        state_e d;
        case (op)
            OPC_REG:   d = ST_REXEC;
            OPC_LOAD:  d = ST_LADDR;
            OPC_STORE: d = ST_SADDR;
            OPC_BEQ:   d = ST_BRANCH;
            OPC_JUMP:  d = ST_JUMP;
            default:   d = ST_ILLEGAL;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/seqctl_state_reg.sv
module seqctl_state_reg
    import seqctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_e nxt,
    output state_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_FETCH;
        else     cur <= nxt;
    end
endmodule

// File: rtl/seqctl_next.sv
module seqctl_next
    import seqctl_pkg::*;
(
    input  state_e           cur,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_ovf,
    output state_e           nxt
);
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:   nxt = ST_DECODE;
            ST_DECODE:  nxt = dispatch(opcode);   // only cycle that reads opcode
            ST_LADDR:   nxt = ST_MREAD;
            ST_MREAD:   nxt = ST_LDWB;
            ST_LDWB:    nxt = ST_FETCH;
            ST_SADDR:   nxt = ST_MWRITE;
            ST_MWRITE:  nxt = ST_FETCH;
            ST_REXEC:   nxt = alu_ovf ? ST_OVFL : ST_RWB;  // only cycle that reads overflow
            ST_RWB:     nxt = ST_FETCH;
            ST_BRANCH:  nxt = ST_FETCH;
            ST_JUMP:    nxt = ST_FETCH;
            ST_ILLEGAL: nxt = ST_TRAP;
            ST_OVFL:    nxt = ST_TRAP;
            ST_TRAP:    nxt = ST_FETCH;
            default:    nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/seqctl_out_dec.sv
module seqctl_out_dec
    import seqctl_pkg::*;
(
    input  state_e cur,
    output ctrl_t  ctrl
);
    always_comb begin
        ctrl = CTRL_IDLE;
        case (cur)
            ST_FETCH: begin
                ctrl.mem_rd = 1'b1;
                ctrl.ir_ld  = 1'b1;
                ctrl.b_sel  = BSEL_FOUR;
                ctrl.pc_ld  = 1'b1;
                ctrl.pc_src = PCS_ALU;
            end
            ST_DECODE: begin
                ctrl.b_sel  = BSEL_IMMSH;
            end
            ST_LADDR, ST_SADDR: begin
                ctrl.a_reg  = 1'b1;
                ctrl.b_sel  = BSEL_IMM;
            end
            ST_MREAD: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.addr_data = 1'b1;
            end
            ST_LDWB: begin
                ctrl.rf_we  = 1'b1;
                ctrl.wb_mem = 1'b1;
            end
            ST_MWRITE: begin
                ctrl.mem_wr    = 1'b1;
                ctrl.addr_data = 1'b1;
            end
            ST_REXEC: begin
                ctrl.a_reg  = 1'b1;
                ctrl.alu_op = AOP_FUNC;
            end
            ST_RWB: begin
                ctrl.dst_rd = 1'b1;
                ctrl.rf_we  = 1'b1;
            end
            ST_BRANCH: begin
                ctrl.a_reg      = 1'b1;
                ctrl.alu_op     = AOP_SUB;
                ctrl.pc_ld_cond = 1'b1;
                ctrl.pc_src     = PCS_ALUREG;
            end
            ST_JUMP: begin
                ctrl.pc_ld  = 1'b1;
                ctrl.pc_src = PCS_JTGT;
            end
            ST_ILLEGAL: begin
                ctrl.cause_ld   = 1'b1;
                ctrl.cause_code = CAUSE_ILLEGAL;
            end
            ST_OVFL: begin
                ctrl.cause_ld   = 1'b1;
                ctrl.cause_code = CAUSE_OVF;
            end
            ST_TRAP: begin
                ctrl.epc_ld = 1'b1;
                ctrl.b_sel  = BSEL_FOUR;
                ctrl.alu_op = AOP_SUB;
                ctrl.pc_ld  = 1'b1;
                ctrl.pc_src = PCS_HANDLER;
            end
            default: ctrl = CTRL_IDLE;
        endcase
    end
endmodule

// File: rtl/seqctl_top.sv
module seqctl_top
    import seqctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_ovf,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             addr_sel_data,
    output logic             ir_load,
    output logic             alu_a_sel,
    output logic [BSEL_W-1:0] alu_b_sel,
    output logic [AOP_W-1:0] alu_op,
    output logic             pc_load,
    output logic             pc_load_cond,
    output logic [PCS_W-1:0] pc_src,
    output logic             wr_dst_rd,
    output logic             rf_we,
    output logic             wb_from_mem,
    output logic             epc_load,
    output logic             cause_load,
    output logic             cause_code
);
    state_e cur_st;
    state_e nxt_st;
    ctrl_t  ctrl;

    seqctl_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_st),
        .cur (cur_st)
    );

    seqctl_next u_next (
        .cur     (cur_st),
        .opcode  (opcode),
        .alu_ovf (alu_ovf),
        .nxt     (nxt_st)
    );

    seqctl_out_dec u_dec (
        .cur  (cur_st),
        .ctrl (ctrl)
    );

    assign mem_rd        = ctrl.mem_rd;
    assign mem_wr        = ctrl.mem_wr;
    assign addr_sel_data = ctrl.addr_data;
    assign ir_load       = ctrl.ir_ld;
    assign alu_a_sel     = ctrl.a_reg;
    assign alu_b_sel     = ctrl.b_sel;
    assign alu_op        = ctrl.alu_op;
    assign pc_load       = ctrl.pc_ld;
    assign pc_load_cond  = ctrl.pc_ld_cond;
    assign pc_src        = ctrl.pc_src;
    assign wr_dst_rd     = ctrl.dst_rd;
    assign rf_we         = ctrl.rf_we;
    assign wb_from_mem   = ctrl.wb_mem;
    assign epc_load      = ctrl.epc_ld;
    assign cause_load    = ctrl.cause_ld;
    assign cause_code    = ctrl.cause_code;
endmodule

// File: rtl/seqctl_chk.sv
module seqctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_ovf,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_load,
    input logic       alu_a_sel,
    input logic [1:0] alu_b_sel,
    input logic [1:0] alu_op,
    input logic       pc_load,
    input logic       pc_load_cond,
    input logic [1:0] pc_src,
    input logic       wr_dst_rd,
    input logic       rf_we,
    input logic       wb_from_mem,
    input logic       epc_load,
    input logic       cause_load,
    input logic       cause_code
);
    logic in_rexec;
    assign in_rexec = alu_a_sel && (alu_b_sel == 2'd0) && (alu_op == 2'd2);

    // R1
    rst_to_fetch_chk: assert property (@(posedge clk)
        rst |=> (ir_load && mem_rd && pc_load && (pc_src == 2'd0) && !rf_we && !mem_wr));

    // R3
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> ((alu_b_sel == 2'd3) && !mem_rd && !mem_wr && !pc_load && !rf_we && !ir_load));

    // R4
    rexec_completes_chk: assert property (@(posedge clk) disable iff (rst)
        (in_rexec && !alu_ovf) |=> (rf_we && wr_dst_rd && !wb_from_mem));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_rexec && alu_ovf) |=> (cause_load && cause_code && !rf_we));

    // R9
    illegal_to_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (cause_load && !cause_code) |=> (epc_load && pc_load && (pc_src == 2'd3)
                                         && (alu_op == 2'd1) && (alu_b_sel == 2'd1) && !alu_a_sel));

    // R11
    trap_returns_chk: assert property (@(posedge clk) disable iff (rst)
        epc_load |=> (ir_load && mem_rd && !epc_load));

    // R7
    branch_returns_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load_cond |=> (ir_load && !pc_load_cond));

    // R7
    pc_load_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_load, pc_load_cond}));
endmodule

bind seqctl_top seqctl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .alu_ovf      (alu_ovf),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .ir_load      (ir_load),
    .alu_a_sel    (alu_a_sel),
    .alu_b_sel    (alu_b_sel),
    .alu_op       (alu_op),
    .pc_load      (pc_load),
    .pc_load_cond (pc_load_cond),
    .pc_src       (pc_src),
    .wr_dst_rd    (wr_dst_rd),
    .rf_we        (rf_we),
    .wb_from_mem  (wb_from_mem),
    .epc_load     (epc_load),
    .cause_load   (cause_load),
    .cause_code   (cause_code)
);

// File: tb/sim_seqctl_top.sv
module sim_seqctl_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;

    // bench-side step identifiers
    localparam int P_F  = 0;
    localparam int P_D  = 1;
    localparam int P_MA = 2;
    localparam int P_MR = 3;
    localparam int P_LW = 4;
    localparam int P_MW = 5;
    localparam int P_RX = 6;
    localparam int P_RW = 7;
    localparam int P_BR = 8;
    localparam int P_J  = 9;
    localparam int P_IL = 10;
    localparam int P_OV = 11;
    localparam int P_EX = 12;

    // instruction classes
    localparam int CL_REG = 0;
    localparam int CL_LD  = 1;
    localparam int CL_ST  = 2;
    localparam int CL_BEQ = 3;
    localparam int CL_J   = 4;
    localparam int CL_ILL = 5;
    localparam int CL_OVF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       alu_ovf = 1'b0;

    logic       mem_rd, mem_wr, addr_sel_data, ir_load, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op, pc_src;
    logic       pc_load, pc_load_cond, wr_dst_rd, rf_we, wb_from_mem;
    logic       epc_load, cause_load, cause_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    seqctl_top u0 (
        .clk (clk), .rst (rst), .opcode (opcode), .alu_ovf (alu_ovf),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .addr_sel_data (addr_sel_data),
        .ir_load (ir_load), .alu_a_sel (alu_a_sel), .alu_b_sel (alu_b_sel),
        .alu_op (alu_op), .pc_load (pc_load), .pc_load_cond (pc_load_cond),
        .pc_src (pc_src), .wr_dst_rd (wr_dst_rd), .rf_we (rf_we),
        .wb_from_mem (wb_from_mem), .epc_load (epc_load),
        .cause_load (cause_load), .cause_code (cause_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [18:0] got;
    assign got = {mem_rd, mem_wr, addr_sel_data, ir_load, alu_a_sel, alu_b_sel, alu_op,
                  pc_load, pc_load_cond, pc_src, wr_dst_rd, rf_we, wb_from_mem,
                  epc_load, cause_load, cause_code};

    function automatic logic [18:0] vec(
        input logic mr, input logic mw, input logic ad, input logic ir, input logic as,
        input logic [1:0] bs, input logic [1:0] op, input logic pl, input logic pc,
        input logic [1:0] ps, input logic dst, input logic we, input logic wb,
        input logic epc, input logic cl, input logic cc);
        return {mr, mw, ad, ir, as, bs, op, pl, pc, ps, dst, we, wb, epc, cl, cc};
    endfunction

    function automatic logic [18:0] exp_vec(input int ph);
        case (ph)
            P_F:  return vec(1,0,0,1,0,2'd1,2'd0,1,0,2'd0,0,0,0,0,0,0);
            P_D:  return vec(0,0,0,0,0,2'd3,2'd0,0,0,2'd0,0,0,0,0,0,0);
            P_MA: return vec(0,0,0,0,1,2'd2,2'd0,0,0,2'd0,0,0,0,0,0,0);
            P_MR: return vec(1,0,1,0,0,2'd0,2'd0,0,0,2'd0,0,0,0,0,0,0);
            P_LW: return vec(0,0,0,0,0,2'd0,2'd0,0,0,2'd0,0,1,1,0,0,0);
            P_MW: return vec(0,1,1,0,0,2'd0,2'd0,0,0,2'd0,0,0,0,0,0,0);
            P_RX: return vec(0,0,0,0,1,2'd0,2'd2,0,0,2'd0,0,0,0,0,0,0);
            P_RW: return vec(0,0,0,0,0,2'd0,2'd0,0,0,2'd0,1,1,0,0,0,0);
            P_BR: return vec(0,0,0,0,1,2'd0,2'd1,0,1,2'd1,0,0,0,0,0,0);
            P_J:  return vec(0,0,0,0,0,2'd0,2'd0,1,0,2'd2,0,0,0,0,0,0);
            P_IL: return vec(0,0,0,0,0,2'd0,2'd0,0,0,2'd0,0,0,0,0,1,0);
            P_OV: return vec(0,0,0,0,0,2'd0,2'd0,0,0,2'd0,0,0,0,0,1,1);
            default: return vec(0,0,0,0,0,2'd1,2'd1,1,0,2'd3,0,0,0,1,0,0); // P_EX
        endcase
    endfunction

    function automatic int len_of(input int cls);
        case (cls)
            CL_LD, CL_OVF:   return 5;
            CL_BEQ, CL_J:    return 3;
            default:         return 4;
        endcase
    endfunction

    function automatic int phase_of(input int cls, input int k);
        if (k == 0) return P_F;
        if (k == 1) return P_D;
        case (cls)
            CL_REG: return (k == 2) ? P_RX : P_RW;
            CL_LD:  return (k == 2) ? P_MA : ((k == 3) ? P_MR : P_LW);
            CL_ST:  return (k == 2) ? P_MA : P_MW;
            CL_BEQ: return P_BR;
            CL_J:   return P_J;
            CL_ILL: return (k == 2) ? P_IL : P_EX;
            default: return (k == 2) ? P_RX : ((k == 3) ? P_OV : P_EX);
        endcase
    endfunction

    function automatic string req_of(input int cls, input int ph);
        case (ph)
            P_F:  return "R2";
            P_D:  return "R3";
            P_MA: return (cls == CL_ST) ? "R6" : "R5";
            P_MR, P_LW: return "R5";
            P_MW: return "R6";
            P_RX: return (cls == CL_OVF) ? "R10" : "R4";
            P_RW: return "R4";
            P_BR: return "R7";
            P_J:  return "R8";
            P_IL: return "R9";
            P_OV: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [5:0] pick_illegal();
        logic [5:0] v;
        do begin
            v = 6'($urandom);
        end while (v == 6'h00 || v == 6'h23 || v == 6'h2B || v == 6'h04 || v == 6'h02);
        return v;
    endfunction

    function automatic logic [5:0] op_of(input int cls);
        case (cls)
            CL_REG, CL_OVF: return 6'h00;
            CL_LD:  return 6'h23;
            CL_ST:  return 6'h2B;
            CL_BEQ: return 6'h04;
            CL_J:   return 6'h02;
            default: return pick_illegal();
        endcase
    endfunction

    task automatic check_vec(input int ph, input string tag);
        logic [18:0] e;
        e = exp_vec(ph);
        checks++;
        if (got !== e) begin
            failures++;
            $display("FAIL %s step=%0d actual=%b expected=%b", tag, ph, got, e);
        end
    endtask

    // Called at a falling edge with the sequencer in fetch.
    task automatic run_instr(input int cls, input logic [5:0] op, input int abort_at);
        for (int k = 0; k < len_of(cls); k++) begin
            int ph;
            ph = phase_of(cls, k);
            check_vec(ph, req_of(cls, ph));
            if (k == abort_at) begin
                rst = 1'b1;
                opcode = 6'($urandom);
                alu_ovf = 1'($urandom);
                @(negedge clk);
                check_vec(P_F, "R1");
                rst = 1'b0;
                return;
            end
            // R12: junk on the inputs outside the cycles that may read them
            opcode  = (ph == P_D)  ? op : 6'($urandom);
            alu_ovf = (ph == P_RX) ? (cls == CL_OVF) : 1'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1;
        @(negedge clk);
        check_vec(P_F, "R1");
        @(negedge clk);
        check_vec(P_F, "R1");
        rst = 1'b0;

        // directed: every class once, then boundary opcodes
        for (int c = CL_REG; c <= CL_OVF; c++) run_instr(c, op_of(c), -1);
        run_instr(CL_ILL, 6'h3F, -1);   // R9 all-ones opcode
        run_instr(CL_ILL, 6'h01, -1);   // R9 neighbour of jump
        run_instr(CL_ILL, 6'h22, -1);   // R9 neighbour of load
        run_instr(CL_ILL, 6'h05, -1);   // R9 neighbour of branch
        run_instr(CL_OVF, 6'h00, -1);   // R10 back to back with
        run_instr(CL_REG, 6'h00, -1);   // R4 a clean execute
        run_instr(CL_LD, 6'h23, 3);     // R1 reset during memory read
        run_instr(CL_OVF, 6'h00, 3);    // R1 reset in the overflow cause cycle
        run_instr(CL_ILL, 6'h3F, 3);    // R1 reset in the handler-entry cycle

        for (int i = 0; i < N_RANDOM; i++) begin
            int c;
            c = int'($urandom_range(CL_OVF, CL_REG));
            run_instr(c, op_of(c), ((i % 37) == 5) ? int'($urandom_range(len_of(c) - 1, 0)) : -1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule